// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses for one SDRAM READ or WRITE burst. A 4-bit mode word sets the burst length and the burst type. A one-cycle start pulse carries the first column. From the next cycle on, the block drives one column address per clock with a valid strobe. A last flag marks the final beat. READ and WRITE bursts use the same programmed length, so the sequencer never sees the command type.

Fixed-length bursts stay inside an aligned block of columns and wrap at its edge. The column bits above the burst-length offset keep the values of the start column. In sequential order the offset counts up. In interleaved order it is the start offset XOR the beat number. The full-page setting walks through every column of the page, wrapping at the top, until a terminate input ends it. Reserved mode settings raise an error flag and give a single-beat access. A fresh start pulse during a burst replaces that burst.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, col_last and mode_err are all 0.
- R2: A start pulse in cycle n gives col_valid=1 and col_addr=start_col in cycle n+1. One further address follows on each cycle until the burst ends.
- R3: Length codes mode_word[2:0] are 000=1, 001=2, 010=4 and 011=8 beats. For these lengths the column bits at and above log2(length) stay equal to those of start_col for every beat.
- R4: With mode_word[3]=0 (sequential), the low log2(length) bits of beat i equal (start offset + i) modulo the length.
- R5: With mode_word[3]=1 (interleaved), the low log2(length) bits of beat i equal the start offset XOR i.
- R6: Code 111 with mode_word[3]=0 is full page. Beat i is (start_col + i) modulo 2^COL_W, and col_last stays 0 until a terminate.
- R7: If stop is high during a valid beat, that beat shows col_last=1 and col_valid is 0 on the next cycle. If stop is high while idle, it has no effect.
- R8: col_last is 1 on the final beat of a fixed-length burst, and col_valid is 0 on the cycle after it unless a new start arrived.
- R9: Codes 100, 101 and 110, and code 111 with mode_word[3]=1, are reserved. Each sets mode_err=1 from the first beat and gives one beat at start_col with col_last=1. mode_err keeps its value until the next start.
- R10: A start pulse during a burst aborts that burst. The next cycle shows beat 0 of the new burst.
- R11: mode_word and start_col are sampled only on the start cycle. Changes to them during a burst do not alter its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 4 | [2:0] length code, [3] burst type |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Burst terminate |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | col_addr holds a beat |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Latched mode of the burst is reserved |

## Verification
The assertions assume start is a single-cycle pulse whenever it is not deliberately used to abort a burst. They also assume stop only matters in cycles where col_valid is high. The stimulus issues each start for exactly one cycle, applies stop on chosen beats of full-page bursts or while idle, and re-issues start mid-burst only in the dedicated abort case. The sweep covers every length code and both types. It uses start columns whose low three bits take every value and whose upper bits vary. During each burst the bench scrambles mode_word and start_col.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err
);

  logic             active, ilv, full, err;
  logic [COL_W-1:0] base, idx, mask;
  logic [COL_W-1:0] d_mask;
  logic             d_full, d_err;
  logic [COL_W-1:0] step;
  logic             end_beat;

  always_comb begin
    d_mask = '0;
    d_full = 1'b0;
    d_err  = 1'b0;
    case (mode_word[2:0])
      3'b000: d_mask = '0;
      3'b001: d_mask = COL_W'(1);
      3'b010: d_mask = COL_W'(3);
      3'b011: d_mask = COL_W'(7);
      3'b111: if (mode_word[3]) d_err = 1'b1; else d_full = 1'b1;
      default: d_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ilv    <= 1'b0;
      full   <= 1'b0;
      err    <= 1'b0;
      base   <= '0;
      idx    <= '0;
      mask   <= '0;
    end else if (start) begin
      active <= 1'b1;
      ilv    <= mode_word[3];
      full   <= d_full;
      err    <= d_err;
      base   <= start_col;
      idx    <= '0;
      mask   <= d_mask;
    end else if (active) begin
      if (col_last) active <= 1'b0;
      else          idx    <= idx + 1'b1;
    end
  end

  assign step      = ilv ? (base ^ idx) : (base + idx);
  assign end_beat  = !full && (idx == mask);
  assign col_addr  = full ? (base + idx) : ((base & ~mask) | (step & mask));
  assign col_valid = active;
  assign col_last  = active && (end_beat || stop);
  assign mode_err  = err;

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col_addr == $past(start_col));
  // R8
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last && !start |=> !col_valid);
  // R6
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && full && !stop |-> !col_last);
  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && mode_err |-> col_last);
  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !start && !ilv && !full |=>
      ((col_addr - $past(col_addr)) & $past(mask)) == COL_W'(1));
  // R3
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !start && !full |=>
      (col_addr & ~$past(mask)) == ($past(col_addr) & ~$past(mask)));

endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_word = '0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       stop = 1'b0;
  logic [8:0] col_addr;
  logic       col_valid, col_last, mode_err;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(9)) uut (.clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .start(start), .start_col(start_col), .stop(stop), .col_addr(col_addr),
    .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_err(input logic [3:0] mw);
    return (mw[2:0] inside {3'b100, 3'b101, 3'b110}) || (mw[2:0] == 3'b111 && mw[3]);
  endfunction

  function automatic int blen(input logic [3:0] mw);
    if (is_err(mw)) return 1;
    return 1 << mw[1:0];
  endfunction

  task automatic run_burst(input logic [3:0] mw, input int s);
    int bl, m, e, lo;
    bl = blen(mw);
    m = bl - 1;
    @(negedge clk);
    mode_word = mw; start_col = 9'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode_word = ~mw; start_col = ~9'(s);
    for (int i = 0; i < bl; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      lo = mw[3] ? (s ^ i) : (s + i);
      e = (s & ~m & 511) | (lo & m);
      chk(mw[3] ? "R5/R3/R11 addr" : "R4/R3/R11 addr", int'(col_addr), e);
      chk("R2 valid", int'(col_valid), 1);
      chk("R8 last", int'(col_last), (i == bl - 1) ? 1 : 0);
      chk("R9 err", int'(mode_err), int'(is_err(mw)));
    end
    @(negedge clk); #1;
    chk("R8 idle after last", int'(col_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL ALL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid", int'(col_valid), 0);
    chk("R1 last", int'(col_last), 0);
    chk("R1 err", int'(mode_err), 0);
    @(negedge clk); rst_n = 1'b1;

    // R7: stop while idle has no effect
    stop = 1'b1;
    @(negedge clk); #1;
    chk("R7 idle stop", int'(col_valid), 0);
    chk("R7 idle stop last", int'(col_last), 0);
    @(negedge clk); stop = 1'b0;

    // R3 R4 R5 R9 R11 sweep
    for (int t = 0; t < 2; t++)
      for (int c = 0; c < 8; c++) begin
        if (c == 7 && t == 0) continue;
        for (int k = 0; k < 16; k++)
          run_burst({t[0], c[2:0]}, (k * 71) % 512);
      end

    // R6 + R7: full page wraps, ends on stop
    @(negedge clk);
    mode_word = 4'b0111; start_col = 9'd506; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode_word = 4'b1010;
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 11) stop = 1'b1;
      #1;
      chk("R6 page addr", int'(col_addr), (506 + i) % 512);
      chk("R6 page err", int'(mode_err), 0);
      chk(i == 11 ? "R7 stop last" : "R6 no last", int'(col_last), i == 11 ? 1 : 0);
    end
    @(negedge clk); stop = 1'b0; #1;
    chk("R7 ended", int'(col_valid), 0);

    // R10: abort an 8-beat burst with a 4-beat interleaved one
    @(negedge clk);
    mode_word = 4'b0011; start_col = 9'd3; start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    chk("R10 old beat0", int'(col_addr), 3);
    @(negedge clk); #1;
    chk("R10 old beat1", int'(col_addr), 4);
    @(negedge clk);
    mode_word = 4'b1010; start_col = 9'd17; start = 1'b1; #1;
    chk("R10 old beat2", int'(col_addr), 5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); start = 1'b0; #1;
      chk("R10 new addr", int'(col_addr), (17 & ~3) | ((17 ^ i) & 3));
      chk("R10 new last", int'(col_last), i == 3 ? 1 : 0);
    end
    @(negedge clk); #1;
    chk("R10 idle", int'(col_valid), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule